// File: doc/BRIEF.md
# I/O Page Table Walker

This block resolves a device-virtual address (IOVA) to its final page entry by walking a tree of I/O page tables held in memory. A request carries the IOVA, the access being asked for (read, write or both) and the root word taken from a device table entry. That word gives the base of the top table and the level the walk starts at. The walker fetches one 64-bit entry per level through a single-outstanding memory read port. At each step it checks the entry, then either descends or stops.

A directory entry may jump down more than one level at a time. When it does, the IOVA index fields of all the levels it passes over must be zero. Levels must strictly descend. The walk ends with a one-cycle done pulse and a small fault code. On success the leaf entry is returned as read. On a fault the returned entry is zero. Only one walk is in progress at a time, and `busy` covers it.

Top module: `io_walker`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done` and `mem_req_valid` are low, `fault` is 0 and `leaf` is 0.
- R2: A request is taken when `req_valid` is high and `busy` is low. `busy` stays high from the next cycle until `done` pulses. `req_valid` is ignored while `busy` is high.
- R3: The root word holds the table base in bits 51:12 and the start level in bits 11:9. A start level of 0, or one above MAX_LEVEL (6), ends the walk with fault 3 and no memory read.
- R4: For level L, the entry address is {base[51:12], idx, 3'b000}. Here idx is IOVA[s+8:s] with s = 12 + 9*(L-1), and IOVA bits above 63 read as zero.
- R5: Each read is a one-cycle `mem_req_valid` pulse. The next read is not issued before the response to the previous one arrives, so a walk that starts at level L without skipping makes exactly L reads.
- R6: An entry with bit 0 (present) clear ends the walk with fault 1.
- R7: `req_perm` bit 0 asks for read and bit 1 asks for write. Entry bit 61 grants read and bit 62 grants write. Any requested access that is not granted ends the walk with fault 2.
- R8: An entry whose next-level field (bits 11:9) is 0 or 7 is a leaf. The walk ends with fault 0 and `leaf` equal to that entry.
- R9: A directory entry whose next level is not strictly below the current level ends the walk with fault 3.
- R10: When a directory entry goes from level L to level N with N < L-1, any nonzero IOVA index bit of a level strictly between N and L ends the walk with fault 4.
- R11: A response with `mem_rsp_err` high ends the walk with fault 5.
- R12: Checks apply in this order: read error, present, permission, leaf, level order, skipped bits. `done` is a single-cycle pulse, and `leaf` is 0 whenever `fault` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken when idle) |
| req_iova | input | 64 | Device-virtual address to resolve |
| req_perm | input | 2 | Requested access: bit 0 read, bit 1 write |
| req_root | input | 64 | Root word: base 51:12, start level 11:9 |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Entry read request pulse |
| mem_req_addr | output | 52 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| mem_rsp_err | input | 1 | Read response carries an error |
| done | output | 1 | One-cycle pulse when the walk ends |
| fault | output | 3 | 0 ok, 1 not present, 2 permission, 3 level, 4 skipped bits, 5 read error |
| leaf | output | 64 | Leaf entry on success, zero on fault |

## Verification
The bench sweeps every start level against several IOVA patterns and counts the reads each walk makes. A wrong level shift or index width would fetch an entry nobody wrote, which reads back as not present. Skip tests place single set bits just inside and just outside the skipped fields. A mask that is off by one level would either reject a legal walk or accept an illegal one. Other cases cover equal or rising next levels, every requested-versus-granted permission pair, and entries that break two rules at once, so a wrong check order shows up as the wrong fault code. A request raised mid-walk with an invalid root would produce an early fault 3 if it leaked in.

// File: rtl/iopw_pkg.sv
package iopw_pkg;

    localparam int ENTRY_W  = 64;
    localparam int PA_W     = 52;
    localparam int IDX_W    = 9;
    localparam int PAGE_SH  = 12;
    localparam int LVL_W    = 3;
    localparam int BASE_W   = PA_W - PAGE_SH;
    localparam int TOP_LVLS = 6;

    // entry field positions
    localparam int PRES_BIT = 0;
    localparam int NL_LO    = 9;
    localparam int RD_BIT   = 61;
    localparam int WR_BIT   = 62;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_NOTPRES = 3'd1,
        FLT_PERM    = 3'd2,
        FLT_LEVEL   = 3'd3,
        FLT_SKIP    = 3'd4,
        FLT_RDERR   = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } state_e;

    typedef struct packed {
        logic [ENTRY_W-1:0] iova;
        logic [1:0]         perm;
    } walk_ctx_t;

    // low bit of the IOVA field that indexes table level l (1..6)
    function automatic int lvl_shift(input logic [LVL_W-1:0] l);
        return PAGE_SH + IDX_W * (int'(l) - 1);
    endfunction

    function automatic logic [IDX_W-1:0] lvl_index(input logic [ENTRY_W-1:0] va,
                                                   input logic [LVL_W-1:0] l);
        logic [ENTRY_W-1:0] sh;
        sh = va >> lvl_shift(l);
        return sh[IDX_W-1:0];
    endfunction

    // IOVA bits of all levels strictly between nxt and cur
    function automatic logic [ENTRY_W-1:0] skip_mask(input logic [LVL_W-1:0] cur,
                                                     input logic [LVL_W-1:0] nxt);
        logic [ENTRY_W-1:0] m;
        m = '0;
        for (int k = 1; k <= TOP_LVLS; k++) begin
            if (k > int'(nxt) && k < int'(cur))
                m = m | (ENTRY_W'({IDX_W{1'b1}}) << lvl_shift(LVL_W'(k)));
        end
        return m;
    endfunction

endpackage

// File: rtl/iopw_addr.sv
module iopw_addr
    import iopw_pkg::*;
(
    input  logic [BASE_W-1:0]  base,
    input  logic [LVL_W-1:0]   lvl,
    input  logic [ENTRY_W-1:0] iova,
    output logic [PA_W-1:0]    addr
);
    // 4 KiB aligned table, 8-byte entries: index lands in bits 11:3
    always_comb begin
        addr = {base, lvl_index(iova, lvl), 3'b000};
    end
endmodule

// File: rtl/iopw_eval.sv
module iopw_eval
    import iopw_pkg::*;
(
    input  logic               rd_err,
    input  logic               present,
    input  logic [1:0]         grant,
    input  logic [1:0]         want,
    input  logic [LVL_W-1:0]   nl,
    input  logic [LVL_W-1:0]   cur_lvl,
    input  logic [ENTRY_W-1:0] iova,
    output fault_e             verdict,
    output logic               is_leaf
);
    logic [ENTRY_W-1:0] hole;

    always_comb begin
        hole    = iova & skip_mask(cur_lvl, nl);
        verdict = FLT_NONE;
        is_leaf = 1'b0;
        if (rd_err)
            verdict = FLT_RDERR;
        else if (!present)
            verdict = FLT_NOTPRES;
        else if ((want & ~grant) != 2'b00)
            verdict = FLT_PERM;
        else if (nl == 3'd0 || nl == 3'd7)
            is_leaf = 1'b1;
        else if (nl >= cur_lvl)
            verdict = FLT_LEVEL;
        else if (hole != '0)
            verdict = FLT_SKIP;
    end
endmodule

// File: rtl/iopw_fsm.sv
module iopw_fsm
    import iopw_pkg::*;
#(
    parameter int MAX_LEVEL = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ENTRY_W-1:0] req_iova,
    input  logic [1:0]         req_perm,
    input  logic [BASE_W-1:0]  root_base,
    input  logic [LVL_W-1:0]   root_lvl,
    input  logic               rsp_valid,
    input  logic [ENTRY_W-1:0] rsp_data,
    input  fault_e             verdict,
    input  logic               is_leaf,
    output logic               busy,
    output logic               issue,
    output logic [BASE_W-1:0]  cur_base,
    output logic [LVL_W-1:0]   cur_lvl,
    output walk_ctx_t          ctx,
    output logic               done,
    output fault_e             fault,
    output logic [ENTRY_W-1:0] leaf
);
    localparam logic [LVL_W-1:0] MAX_L = LVL_W'(MAX_LEVEL);

    state_e state;
    logic   root_bad;

    assign root_bad = (root_lvl == 3'd0) || (root_lvl > MAX_L);
    assign busy     = (state != ST_IDLE);
    assign issue    = (state == ST_ISSUE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            done     <= 1'b0;
            fault    <= FLT_NONE;
            leaf     <= '0;
            cur_base <= '0;
            cur_lvl  <= '0;
            ctx      <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        ctx.iova <= req_iova;
                        ctx.perm <= req_perm;
                        cur_base <= root_base;
                        cur_lvl  <= root_lvl;
                        if (root_bad) begin
                            done  <= 1'b1;
                            fault <= FLT_LEVEL;
                            leaf  <= '0;
                        end else begin
                            state <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (rsp_valid) begin
                        if (verdict != FLT_NONE) begin
                            done  <= 1'b1;
                            fault <= verdict;
                            leaf  <= '0;
                            state <= ST_IDLE;
                        end else if (is_leaf) begin
                            done  <= 1'b1;
                            fault <= FLT_NONE;
                            leaf  <= rsp_data;
                            state <= ST_IDLE;
                        end else begin
                            cur_base <= rsp_data[PA_W-1:PAGE_SH];
                            cur_lvl  <= rsp_data[NL_LO +: LVL_W];
                            state    <= ST_ISSUE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_fault_no_leaf_r12: assert property (@(posedge clk) disable iff (rst)
        (done && fault != FLT_NONE) |-> (leaf == '0));

    p_leaf_shape_r8: assert property (@(posedge clk) disable iff (rst)
        (done && fault == FLT_NONE) |-> (leaf[PRES_BIT] &&
            (leaf[NL_LO +: LVL_W] == 3'd0 || leaf[NL_LO +: LVL_W] == 3'd7)));

    p_descend_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ISSUE && $past(state) == ST_WAIT) |-> (cur_lvl < $past(cur_lvl)));

    p_single_read_r5: assert property (@(posedge clk) disable iff (rst)
        issue |=> !issue);

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && !root_bad) |=> busy);

    p_bad_root_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && root_bad) |=> (done && fault == FLT_LEVEL && !busy));
endmodule

// File: rtl/io_walker.sv
module io_walker
    import iopw_pkg::*;
#(
    parameter int MAX_LEVEL = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [63:0]         req_iova,
    input  logic [1:0]          req_perm,
    input  logic [63:0]         req_root,
    output logic                busy,
    output logic                mem_req_valid,
    output logic [51:0]         mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [63:0]         mem_rsp_data,
    input  logic                mem_rsp_err,
    output logic                done,
    output logic [2:0]          fault,
    output logic [63:0]         leaf
);
    logic [BASE_W-1:0] cur_base;
    logic [LVL_W-1:0]  cur_lvl;
    walk_ctx_t         ctx;
    fault_e            verdict;
    fault_e            fault_q;
    logic              is_leaf;
    logic              unused_root;

    assign unused_root = ^{req_root[63:PA_W], req_root[NL_LO-1:0]};

    iopw_fsm #(.MAX_LEVEL(MAX_LEVEL)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_iova  (req_iova),
        .req_perm  (req_perm),
        .root_base (req_root[PA_W-1:PAGE_SH]),
        .root_lvl  (req_root[NL_LO +: LVL_W]),
        .rsp_valid (mem_rsp_valid),
        .rsp_data  (mem_rsp_data),
        .verdict   (verdict),
        .is_leaf   (is_leaf),
        .busy      (busy),
        .issue     (mem_req_valid),
        .cur_base  (cur_base),
        .cur_lvl   (cur_lvl),
        .ctx       (ctx),
        .done      (done),
        .fault     (fault_q),
        .leaf      (leaf)
    );

    iopw_addr u_addr (
        .base (cur_base),
        .lvl  (cur_lvl),
        .iova (ctx.iova),
        .addr (mem_req_addr)
    );

    iopw_eval u_eval (
        .rd_err  (mem_rsp_err),
        .present (mem_rsp_data[PRES_BIT]),
        .grant   ({mem_rsp_data[WR_BIT], mem_rsp_data[RD_BIT]}),
        .want    (ctx.perm),
        .nl      (mem_rsp_data[NL_LO +: LVL_W]),
        .cur_lvl (cur_lvl),
        .iova    (ctx.iova),
        .verdict (verdict),
        .is_leaf (is_leaf)
    );

    assign fault = fault_q;

    p_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

    p_no_req_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req_valid);
endmodule

// File: tb/io_walker_test.sv
module io_walker_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [63:0] req_iova;
    logic [1:0]  req_perm;
    logic [63:0] req_root;
    logic        busy, mem_req_valid, done;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid, mem_rsp_err;
    logic [63:0] mem_rsp_data;
    logic [2:0]  fault;
    logic [63:0] leaf;

    always #5 clk = ~clk;

    io_walker uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_iova(req_iova),
        .req_perm(req_perm), .req_root(req_root), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_err(mem_rsp_err), .done(done), .fault(fault), .leaf(leaf)
    );

    logic [63:0] mem [logic [51:0]];
    bit          errset [logic [51:0]];
    int          checks = 0, errors = 0;
    int          reads = 0, reqcyc = 0, lat_sel = 0, dones = 0;
    logic [39:0] next_base = 40'h100;
    logic [51:0] path_addr [1:6];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // memory model with 1..3 cycle latency
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            while (mem_req_valid && !rst) begin
                logic [51:0] a;
                int lat;
                a   = mem_req_addr;
                lat = 1 + (lat_sel % 3);
                lat_sel++;
                reads++;
                repeat (lat) @(negedge clk);
                mem_rsp_data  = mem.exists(a) ? mem[a] : 64'h0;
                mem_rsp_err   = errset.exists(a);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_err   = 1'b0;
                mem_rsp_data  = '0;
            end
        end
    end

    // request-cycle and done monitors, sampled away from the edge
    initial forever begin
        @(negedge clk);
        if (mem_req_valid) reqcyc++;
        if (done) dones++;
    end

    function automatic logic [8:0] bidx(input logic [63:0] v, input int l);
        logic [63:0] t;
        t = v >> (12 + 9 * (l - 1));
        return t[8:0];
    endfunction

    function automatic logic [63:0] mk_dir(input logic [39:0] b, input int nl, input logic [1:0] wr_rd);
        return {1'b0, wr_rd, 9'h0, b, 3'(nl), 8'h0, 1'b1};
    endfunction

    function automatic logic [63:0] mk_leaf(input logic [63:0] v, input int nl);
        return {1'b0, 2'b11, 9'h0, v[51:12] ^ 40'h5A5A5, 3'(nl), 8'h0, 1'b1};
    endfunction

    task automatic build(input logic [63:0] v, input int start, input int step,
                         output logic [63:0] root, output logic [63:0] lf);
        logic [39:0] b;
        int lvl;
        mem.delete();
        errset.delete();
        next_base = next_base + 40'h1;
        b    = next_base;
        root = {12'h0, b, 3'(start), 9'h0};
        lvl  = start;
        lf   = mk_leaf(v, 0);
        forever begin
            logic [51:0] a;
            a = {b, bidx(v, lvl), 3'b000};
            path_addr[lvl] = a;
            if (lvl - step < 1) begin
                mem[a] = lf;
                break;
            end
            next_base = next_base + 40'h1;
            mem[a] = mk_dir(next_base, lvl - step, 2'b11);
            b   = next_base;
            lvl = lvl - step;
        end
    endtask

    task automatic walk(input logic [63:0] v, input logic [1:0] p, input logic [63:0] root,
                        output logic [2:0] f, output logic [63:0] lf, output int nr, output int nc);
        int n;
        @(negedge clk);
        reads = 0; reqcyc = 0;
        req_iova = v; req_perm = p; req_root = root; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 300) begin
            @(negedge clk);
            n++;
        end
        f = fault; lf = leaf; nr = reads; nc = reqcyc;
    endtask

    task automatic expect_walk(input string tag, input logic [63:0] v, input logic [1:0] p,
                               input logic [63:0] root, input int ef, input logic [63:0] el,
                               input int er);
        logic [2:0] f; logic [63:0] lf; int nr, nc;
        walk(v, p, root, f, lf, nr, nc);
        chk({tag, " fault"}, 64'(f), 64'(ef));
        chk({tag, " leaf"}, lf, el);
        chk({tag, " reads"}, 64'(nr), 64'(er));
        chk({tag, " R5 request cycles"}, 64'(nc), 64'(er));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] root, lf, v;
        logic [63:0] pats [4];
        pats[0] = 64'h0;
        pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[2] = 64'h0123_4567_89AB_CDEF;
        pats[3] = 64'hFEDC_BA98_7654_3210;
        rst = 1'b1; req_valid = 1'b0; req_iova = '0; req_perm = '0; req_root = '0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", 64'(busy), 64'd0);
        chk("R1 done in reset", 64'(done), 64'd0);
        chk("R1 mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 fault after reset", 64'(fault), 64'd0);
        chk("R1 leaf after reset", leaf, 64'd0);
        chk("R1 busy after reset", 64'(busy), 64'd0);

        // R4 R8 R5: every start level, several IOVA patterns, no skipping
        for (int s = 1; s <= 6; s++)
            for (int i = 0; i < 4; i++) begin
                build(pats[i], s, 1, root, lf);
                expect_walk($sformatf("R4 level %0d pat %0d", s, i), pats[i], 2'b11, root, 0, lf, s);
            end

        // R7: permission pairs at a directory and at the leaf
        for (int rp = 0; rp < 4; rp++)
            for (int ep = 0; ep < 4; ep++) begin
                logic [1:0] req_p, ent_p;
                int bad;
                req_p = 2'(rp); ent_p = 2'(ep);
                bad = ((req_p & ~ent_p) != 2'b00) ? 1 : 0;
                build(pats[2], 2, 1, root, lf);
                mem[path_addr[2]][62:61] = ent_p;
                expect_walk($sformatf("R7 dir req %0d ent %0d", rp, ep), pats[2], req_p, root,
                            bad ? 2 : 0, bad ? 64'h0 : lf, bad ? 1 : 2);
                build(pats[3], 2, 1, root, lf);
                mem[path_addr[1]][62:61] = ent_p;
                lf[62:61] = ent_p;
                expect_walk($sformatf("R7 leaf req %0d ent %0d", rp, ep), pats[3], req_p, root,
                            bad ? 2 : 0, bad ? 64'h0 : lf, 2);
            end

        // R6: not present at each level of a 4-level walk
        for (int k = 4; k >= 1; k--) begin
            build(pats[2], 4, 1, root, lf);
            mem[path_addr[k]][0] = 1'b0;
            expect_walk($sformatf("R6 level %0d", k), pats[2], 2'b01, root, 1, 64'h0, 5 - k);
        end

        // R10: skip 6 -> 3 (levels 5,4 skipped: IOVA bits 56:39)
        v = 64'hFE00_007F_FFFF_F000;
        build(v, 6, 3, root, lf);
        expect_walk("R10 6to3 clean", v, 2'b11, root, 0, lf, 2);
        v = 64'hFE00_007F_FFFF_F000 | (64'h1 << 48);
        build(v, 6, 3, root, lf);
        expect_walk("R10 6to3 bit48", v, 2'b11, root, 4, 64'h0, 1);
        v = 64'hFE00_007F_FFFF_F000 | (64'h1 << 39);
        build(v, 6, 3, root, lf);
        expect_walk("R10 6to3 bit39", v, 2'b11, root, 4, 64'h0, 1);
        v = 64'hFE00_007F_FFFF_F000 | (64'h1 << 56);
        build(v, 6, 3, root, lf);
        expect_walk("R10 6to3 bit56", v, 2'b11, root, 4, 64'h0, 1);
        // R10: skip 6 -> 1 (levels 5..2 skipped: IOVA bits 56:21)
        v = 64'hFE00_0000_001F_F000;
        build(v, 6, 5, root, lf);
        expect_walk("R10 6to1 clean", v, 2'b11, root, 0, lf, 2);
        v = 64'hFE00_0000_001F_F000 | (64'h1 << 21);
        build(v, 6, 5, root, lf);
        expect_walk("R10 6to1 bit21", v, 2'b11, root, 4, 64'h0, 1);
        v = 64'hFE00_0000_001F_F000 | (64'h1 << 38);
        build(v, 6, 5, root, lf);
        expect_walk("R10 6to1 bit38", v, 2'b11, root, 4, 64'h0, 1);

        // R9: next level equal to or above current
        for (int nl = 4; nl <= 6; nl++) begin
            build(pats[1], 4, 1, root, lf);
            mem[path_addr[4]][11:9] = 3'(nl);
            expect_walk($sformatf("R9 4 to %0d", nl), pats[1], 2'b11, root, 3, 64'h0, 1);
        end
        build(pats[1], 4, 1, root, lf);
        mem[path_addr[3]][11:9] = 3'd3;
        expect_walk("R9 3 to 3", pats[1], 2'b11, root, 3, 64'h0, 2);

        // R3: start level out of range, no reads
        build(pats[0], 3, 1, root, lf);
        expect_walk("R3 root level 0", pats[0], 2'b11, {root[63:12], 3'd0, 9'h0}, 3, 64'h0, 0);
        expect_walk("R3 root level 7", pats[0], 2'b11, {root[63:12], 3'd7, 9'h0}, 3, 64'h0, 0);

        // R11: read error at each level
        for (int k = 3; k >= 1; k--) begin
            build(pats[3], 3, 1, root, lf);
            errset[path_addr[k]] = 1'b1;
            expect_walk($sformatf("R11 level %0d", k), pats[3], 2'b11, root, 5, 64'h0, 4 - k);
        end

        // R8: leaf encoded with next level 7
        build(pats[2], 3, 1, root, lf);
        lf[11:9] = 3'd7;
        mem[path_addr[1]] = lf;
        expect_walk("R8 leaf code 7", pats[2], 2'b11, root, 0, lf, 3);

        // R12: entries breaking two rules at once
        build(pats[2], 3, 1, root, lf);
        mem[path_addr[3]][0] = 1'b0;
        mem[path_addr[3]][62:61] = 2'b00;
        expect_walk("R12 notpres over perm", pats[2], 2'b11, root, 1, 64'h0, 1);
        build(pats[2], 3, 1, root, lf);
        mem[path_addr[3]][0] = 1'b0;
        errset[path_addr[3]] = 1'b1;
        expect_walk("R12 err over notpres", pats[2], 2'b11, root, 5, 64'h0, 1);
        build(pats[2], 3, 1, root, lf);
        mem[path_addr[3]][62:61] = 2'b00;
        mem[path_addr[3]][11:9] = 3'd5;
        expect_walk("R12 perm over level", pats[2], 2'b10, root, 2, 64'h0, 1);
        build(64'hFE00_007F_FFFF_F000 | (64'h1 << 45), 6, 3, root, lf);
        mem[path_addr[6]][11:9] = 3'd6;
        expect_walk("R12 level over skip", 64'hFE00_007F_FFFF_F000 | (64'h1 << 45), 2'b11,
                    root, 3, 64'h0, 1);

        // R2: request held high with an invalid root during a walk is ignored
        begin
            logic [63:0] r0;
            int n;
            build(pats[1], 3, 1, r0, lf);
            @(negedge clk);
            dones = 0; reads = 0;
            req_iova = pats[1]; req_perm = 2'b11; req_root = r0; req_valid = 1'b1;
            @(negedge clk);
            chk("R2 busy after accept", 64'(busy), 64'd1);
            req_root = {r0[63:12], 3'd0, 9'h0};
            repeat (3) @(negedge clk);
            chk("R2 busy while ignoring", 64'(busy), 64'd1);
            req_valid = 1'b0;
            n = 0;
            while (!done && n < 300) begin
                @(negedge clk);
                n++;
            end
            chk("R2 walk result fault", 64'(fault), 64'd0);
            chk("R2 walk result leaf", leaf, lf);
            chk("R2 busy low at done", 64'(busy), 64'd0);
            repeat (6) @(negedge clk);
            chk("R2 single done", 64'(dones), 64'd1);
            chk("R2 reads", 64'(reads), 64'd3);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule